// File: doc/BRIEF.md
# Dimension-Ordered Store-and-Forward Mesh Input Port

This block is one input port of a router in a two-dimensional mesh network that moves data in packets. Each packet is eight flits long. The port takes flits from the upstream side and keeps them in a local buffer until all eight have arrived. It then decodes the first flit, the header, to choose exactly one of eight router outputs: four mesh neighbours and up to four local attachment points. Only after that does it raise a request towards the chosen output. When that output grants, the port streams the stored flits out, one flit per clock.

The port's own mesh position and the set of local attachment points that physically exist are fixed at build time through parameters. Routing settles the vertical offset first and the horizontal offset second. It goes to a local attachment point only when both offsets are zero. A header that names a local attachment point this router lacks raises an error pulse. The packet is then thrown away, so the port never waits for a grant that cannot come.

Top module: `xy_saf_inport`

## Requirements
- R1: After reset, `in_ready` is 1 and `req_o`, `out_valid` and `err_o` are 0.
- R2: `in_ready` is 1 only while the buffer is filling and holds fewer than 8 flits. It is 0 from the cycle after the 8th flit is taken until the packet has left or been discarded. Flits offered while `in_ready` is 0 are ignored and do not change the stored packet.
- R3: Header fields: destination row in flit bits [7:5], destination column in bits [4:2], local index in bits [1:0]. Flit bits above bit 7 do not affect routing.
- R4: Rows are compared first. If the destination row is greater than `MY_ROW`, request bit 0 (north) is set. If it is smaller, request bit 2 (south) is set.
- R5: With equal rows, a destination column greater than `MY_COL` sets request bit 1 (east) and a smaller one sets bit 3 (west).
- R6: With equal row and column, request bit 4+index is set (local ports 0 to 3 at bits 4 to 7).
- R7: The request appears exactly two cycles after the clock edge that takes the 8th flit, and never earlier. At most one request bit is ever set.
- R8: The request stays unchanged until `gnt_i` is high on the requested bit at a clock edge. Grant bits at other positions have no effect.
- R9: In the cycle after the granting edge the request is 0. The 8 flits then appear on `out_flit` with `out_valid` high in 8 consecutive cycles, in arrival order. After that, `in_ready` returns to 1.
- R10: If the header selects local index i and bit i of `LOCAL_MASK` is 0, `err_o` is high for exactly the one cycle after the 8th flit is taken. No request is raised, the packet is discarded, and `in_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream offers a flit |
| in_flit | input | FLIT_W | Offered flit |
| in_ready | output | 1 | Port takes the offered flit at this edge |
| req_o | output | 8 | One-hot output request: N, E, S, W, local0 to local3 |
| gnt_i | input | 8 | Grant from the output side, one bit per output |
| out_valid | output | 1 | A stored flit is on `out_flit` |
| out_flit | output | FLIT_W | Outgoing flit |
| err_o | output | 1 | Header names a local port that does not exist |

## Verification
Let E8 be the edge that takes the 8th flit. The error flag and the end of `in_ready` are due in the cycle after E8. The request, or for a bad header the return of `in_ready`, is due one cycle later again. The first outgoing flit is due in the cycle after the granting edge, and the others follow in the next seven cycles. The bench drives inputs and samples outputs only on falling edges, and it counts those edges from each event, so every check falls in exactly the cycle above. During the request wait the bench offers junk flits and wrong-position grants. The exact replay of the original flits then shows that both were ignored.

// File: rtl/xy_saf_pkg.sv
// Shared constants and types for the store-and-forward mesh input port.
// Assumes an 8-output router: four mesh directions plus four local ports.
package xy_saf_pkg;
    localparam int NUM_OUT  = 8;
    localparam int HDR_W    = 8;
    localparam int COORD_W  = 3;
    localparam int LOCAL_N  = 4;
    // output bit positions in the request vector
    localparam int OUT_N    = 0;
    localparam int OUT_E    = 1;
    localparam int OUT_S    = 2;
    localparam int OUT_W    = 3;
    localparam int OUT_LOC0 = 4;

    typedef enum logic [1:0] {
        PS_FILL = 2'd0,
        PS_REQ  = 2'd1,
        PS_SEND = 2'd2
    } port_state_e;
endpackage

// File: rtl/xy_route_dec.sv
// Dimension-ordered route decoder. It settles the row first, then the column,
// then the local index. It takes only the low 8 header bits and assumes the
// router position and the local-port mask are fixed at build time.
module xy_route_dec
    import xy_saf_pkg::*;
#(
    parameter logic [COORD_W-1:0] MY_ROW     = 3'd0,
    parameter logic [COORD_W-1:0] MY_COL     = 3'd0,
    parameter logic [LOCAL_N-1:0] LOCAL_MASK = 4'b0001
) (
    input  logic [HDR_W-1:0]   hdr,
    output logic [NUM_OUT-1:0] route_vec,
    output logic               bad_port
);
    logic [COORD_W-1:0] dst_row;
    logic [COORD_W-1:0] dst_col;
    logic [1:0]         loc_idx;
    logic               here;
    logic [LOCAL_N-1:0] loc_hit;

    assign dst_row = hdr[7:5];
    assign dst_col = hdr[4:2];
    assign loc_idx = hdr[1:0];
    assign here    = (dst_row == MY_ROW) && (dst_col == MY_COL);

    // one select line per local port; an absent port never gets a request
    for (genvar g = 0; g < LOCAL_N; g++) begin : g_loc
        assign loc_hit[g] = here && (loc_idx == g[1:0]) && LOCAL_MASK[g];
    end

    // purpose: rank the decision as vertical, then horizontal, then local
    always_comb begin
        route_vec = '0;
        if (dst_row > MY_ROW)      route_vec[OUT_N] = 1'b1;
        else if (dst_row < MY_ROW) route_vec[OUT_S] = 1'b1;
        else if (dst_col > MY_COL) route_vec[OUT_E] = 1'b1;
        else if (dst_col < MY_COL) route_vec[OUT_W] = 1'b1;
        else route_vec[OUT_LOC0 +: LOCAL_N] = loc_hit;
    end

    assign bad_port = here && !LOCAL_MASK[loc_idx];
endmodule

// File: rtl/saf_flit_buf.sv
// Packet buffer holding exactly DEPTH flits. It fills in order and drains in
// order. The counts clear when the last flit is read or when clear_i is high.
// Assumes the controller never stores while full and never reads while empty.
module saf_flit_buf #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_i,
    input  logic [FLIT_W-1:0] wr_data,
    input  logic              forward_i,
    input  logic              clear_i,
    output logic [FLIT_W-1:0] rd_data,
    output logic [7:0]        head_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              last_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [FLIT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  wr_cnt;
    logic [IDX_W-1:0]  rd_idx;

    // purpose: write the incoming flit at the fill position
    always_ff @(posedge clk) begin
        if (store_i) mem[wr_cnt[IDX_W-1:0]] <= wr_data;
    end

    // purpose: track fill count and read position, reset on drain or discard
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            wr_cnt <= '0;
            rd_idx <= '0;
        end else begin
            if (store_i) wr_cnt <= wr_cnt + 1'b1;
            if (forward_i) begin
                if (last_o) begin
                    wr_cnt <= '0;
                    rd_idx <= '0;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
        end
    end

    assign rd_data = mem[rd_idx];
    assign head_o  = mem[0][7:0];
    assign full_o  = (wr_cnt == CNT_W'(DEPTH));
    assign empty_o = (wr_cnt == '0);
    assign last_o  = (rd_idx == IDX_W'(DEPTH - 1));
endmodule

// File: rtl/saf_port_fsm.sv
// Port sequencer: fill, then request, then send. Raises the request only on
// a full buffer. Discards a packet whose local port does not exist. Assumes
// the grant bits are sampled only at the position that was requested.
module saf_port_fsm
    import xy_saf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               buf_full,
    input  logic               buf_last,
    input  logic [NUM_OUT-1:0] route_vec,
    input  logic               bad_port,
    input  logic [NUM_OUT-1:0] gnt_i,
    output logic               in_ready,
    output logic               store,
    output logic               forward,
    output logic               discard,
    output logic [NUM_OUT-1:0] req_o,
    output logic               out_valid,
    output logic               err_o
);
    port_state_e state, state_nx;
    logic        grant_hit;

    // purpose: hold the sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_FILL;
        else        state <= state_nx;
    end

    assign in_ready  = (state == PS_FILL) && !buf_full;
    assign store     = in_valid && in_ready;
    assign req_o     = (state == PS_REQ) ? route_vec : '0;
    assign grant_hit = |(req_o & gnt_i);
    assign out_valid = (state == PS_SEND);
    assign forward   = out_valid;
    assign err_o     = (state == PS_FILL) && buf_full && bad_port;
    assign discard   = err_o;

    // purpose: pick the next state from buffer status and grant
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_FILL: if (buf_full && !bad_port) state_nx = PS_REQ;
            PS_REQ:  if (grant_hit)             state_nx = PS_SEND;
            PS_SEND: if (buf_last)              state_nx = PS_FILL;
            default:                            state_nx = PS_FILL;
        endcase
    end
endmodule

// File: rtl/xy_saf_inport.sv
// Top of the store-and-forward input port. It buffers a whole packet, routes
// it by row then column then local index, requests one output and drains on
// grant. Assumes FLIT_W >= 8 and an 8-flit packet; bits above 7 carry no
// routing meaning.
module xy_saf_inport
    import xy_saf_pkg::*;
#(
    parameter int                 FLIT_W     = 16,
    parameter int                 PKT_FLITS  = 8,
    parameter logic [COORD_W-1:0] MY_ROW     = 3'd3,
    parameter logic [COORD_W-1:0] MY_COL     = 3'd4,
    parameter logic [LOCAL_N-1:0] LOCAL_MASK = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FLIT_W-1:0]  in_flit,
    output logic               in_ready,
    output logic [NUM_OUT-1:0] req_o,
    input  logic [NUM_OUT-1:0] gnt_i,
    output logic               out_valid,
    output logic [FLIT_W-1:0]  out_flit,
    output logic               err_o
);
    if (FLIT_W < HDR_W) begin : g_width_bad
        $error("FLIT_W must be at least 8");
    end

    logic               buf_store;
    logic               buf_forward;
    logic               buf_clear;
    logic               buf_full;
    logic               buf_empty;
    logic               buf_last;
    logic [7:0]         head;
    logic [NUM_OUT-1:0] route_vec;
    logic               bad_port;

    saf_flit_buf #(.FLIT_W(FLIT_W), .DEPTH(PKT_FLITS)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .store_i(buf_store), .wr_data(in_flit),
        .forward_i(buf_forward), .clear_i(buf_clear),
        .rd_data(out_flit), .head_o(head),
        .full_o(buf_full), .empty_o(buf_empty), .last_o(buf_last)
    );

    xy_route_dec #(.MY_ROW(MY_ROW), .MY_COL(MY_COL), .LOCAL_MASK(LOCAL_MASK)) u_dec (
        .hdr(head), .route_vec(route_vec), .bad_port(bad_port)
    );

    saf_port_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .buf_full(buf_full), .buf_last(buf_last),
        .route_vec(route_vec), .bad_port(bad_port), .gnt_i(gnt_i),
        .in_ready(in_ready), .store(buf_store), .forward(buf_forward),
        .discard(buf_clear), .req_o(req_o), .out_valid(out_valid), .err_o(err_o)
    );
endmodule

// File: rtl/xy_saf_inport_chk.sv
// Property checker for the input port. It watches the top-level handshake and
// the buffer empty flag, and is attached by bind below.
module xy_saf_inport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [7:0] req_o,
    input logic [7:0] gnt_i,
    input logic       out_valid,
    input logic       err_o,
    input logic       buf_empty
);
    // R7
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_o));

    // R7
    req_not_while_filling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_o) |-> (!in_ready && !out_valid));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_o) && !(|(req_o & gnt_i))) |=> (req_o == $past(req_o)));

    // R9
    grant_to_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_o & gnt_i)) |=> ((req_o == 8'h00) && out_valid));

    // R2
    no_fill_during_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10
    err_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (buf_empty && in_ready && !err_o));
endmodule

bind xy_saf_inport xy_saf_inport_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .req_o(req_o),
    .gnt_i(gnt_i), .out_valid(out_valid), .err_o(err_o), .buf_empty(buf_empty)
);

// File: tb/xy_saf_inport_tb_top.sv
// Bench: directed headers for every route class, then seeded random packets.
module xy_saf_inport_tb_top;
    localparam int         FW    = 12;
    localparam logic [2:0] ROW   = 3'd3;
    localparam logic [2:0] COL   = 3'd4;
    localparam logic [3:0] LMASK = 4'b0101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [FW-1:0] in_flit = '0;
    logic          in_ready;
    logic [7:0]    req_o;
    logic [7:0]    gnt_i = '0;
    logic          out_valid;
    logic [FW-1:0] out_flit;
    logic          err_o;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    logic [FW-1:0] pkt [8];

    xy_saf_inport #(.FLIT_W(FW), .PKT_FLITS(8), .MY_ROW(ROW), .MY_COL(COL),
                    .LOCAL_MASK(LMASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .req_o(req_o), .gnt_i(gnt_i),
        .out_valid(out_valid), .out_flit(out_flit), .err_o(err_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected request vector, or zero for a missing local port
    function automatic logic [7:0] exp_route(input logic [7:0] h);
        logic [2:0] r = h[7:5];
        logic [2:0] c = h[4:2];
        logic [7:0] v = '0;
        if (r > ROW)      v[0] = 1'b1;
        else if (r < ROW) v[2] = 1'b1;
        else if (c > COL) v[1] = 1'b1;
        else if (c < COL) v[3] = 1'b1;
        else if (LMASK[h[1:0]]) v[4 + h[1:0]] = 1'b1;
        return v;
    endfunction

    // send one packet with the given header byte, then check the outcome
    task automatic run_pkt(input logic [7:0] hdr, input int gaps);
        logic [7:0] ev;
        bit         bad;
        int         waitn;
        ev  = exp_route(hdr);
        bad = (ev == 8'h00);
        for (int i = 0; i < 8; i++) begin
            pkt[i] = FW'($urandom);
            if (i == 0) pkt[i][7:0] = hdr;
        end
        for (int i = 0; i < 8; i++) begin
            if (gaps != 0 && ($urandom % 3) == 0) begin
                @(negedge clk);
                chk(in_ready == 1'b1, "R2 ready while filling", 32'(in_ready), 1);
                in_valid = 1'b0;
            end
            @(negedge clk);
            chk(in_ready == 1'b1, "R2 ready while filling", 32'(in_ready), 1);
            chk(req_o == 8'h00, "R7 no request before full", 32'(req_o), 0);
            in_valid = 1'b1;
            in_flit  = pkt[i];
        end
        // cycle after the 8th flit is taken
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 not ready when full", 32'(in_ready), 0);
        chk(err_o == bad, "R10 error flag", 32'(err_o), 32'(bad));
        chk(req_o == 8'h00, "R7 request not yet raised", 32'(req_o), 0);
        in_valid = !bad;
        in_flit  = FW'($urandom);
        @(negedge clk);
        if (bad) begin
            chk(in_ready == 1'b1 && err_o == 1'b0 && req_o == 8'h00,
                "R10 discard and resume", {in_ready, err_o, req_o}, 32'h200);
            return;
        end
        chk(req_o == ev, "R3 R4 R5 R6 R7 route", 32'(req_o), 32'(ev));
        waitn = $urandom % 4;
        for (int w = 0; w < waitn; w++) begin
            gnt_i   = ~ev & 8'($urandom);
            in_flit = FW'($urandom);
            @(negedge clk);
            chk(req_o == ev, "R8 request held", 32'(req_o), 32'(ev));
            chk(in_ready == 1'b0 && out_valid == 1'b0, "R2 R8 idle while waiting",
                {in_ready, out_valid}, 0);
        end
        gnt_i    = ev | 8'($urandom);
        in_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            gnt_i = '0;
            if (i == 0) chk(req_o == 8'h00, "R9 request drops", 32'(req_o), 0);
            chk(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 1);
            chk(out_flit == pkt[i], "R9 R2 flit order", 32'(out_flit), 32'(pkt[i]));
        end
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 back to fill",
            {out_valid, in_ready}, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
        chk(req_o == 8'h00 && out_valid == 1'b0 && err_o == 1'b0, "R1 outputs idle",
            {req_o, out_valid, err_o}, 0);
        run_pkt({3'd6, 3'd0, 2'd3}, 0);   // R4 north
        run_pkt({3'd0, 3'd7, 2'd0}, 0);   // R4 south
        run_pkt({3'd3, 3'd7, 2'd1}, 1);   // R5 east
        run_pkt({3'd3, 3'd0, 2'd2}, 1);   // R5 west
        run_pkt({3'd3, 3'd4, 2'd0}, 0);   // R6 local0
        run_pkt({3'd3, 3'd4, 2'd2}, 0);   // R6 local2
        run_pkt({3'd3, 3'd4, 2'd1}, 0);   // R10 missing local1
        run_pkt({3'd3, 3'd4, 2'd3}, 1);   // R10 missing local3
        run_pkt({3'd7, 3'd4, 2'd0}, 0);   // R4 boundary row
        run_pkt({3'd3, 3'd5, 2'd0}, 0);   // R5 boundary column
        for (int n = 0; n < 40; n++) begin
            run_pkt(8'($urandom), 1);     // R3 upper flit bits random
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule